// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits after an address translation has finished and decides whether the memory access that asked for it may go ahead. It is given the kind of access (load, store or instruction fetch), whether the requester runs in supervisor or user mode, the 3-bit permission field of the page found, the page's modified bit and the walk's fault type and level. One cycle after a request it reports grant or deny, whether write permission may be installed in a translation cache entry, and, on a fault, a trap request. The trap request says whether the fault was an instruction fault or a data fault.

Every fault is logged in a fault status register and a fault address register. If a second fault arrives before the status was read, the overflow bit is kept. A read of the status register clears it. When no-fault mode is on, or when traps are disabled, a fault still gets logged. In that case the access is granted with read and write permission and no trap is raised.

Top module: `page_perm_check`

## Requirements
- R1: The access index is {store, fetch, supervisor} (bit 2 set for stores, bit 1 set for fetches, bit 0 set in supervisor mode). It is logged in status bits [7:5] on every fault. Access kind encoding: 0 load, 1 store, 2 fetch.
- R2: When there is no walk fault, a protection error (code 2, status bits [1:0] = 2'b10) applies in these cases. A load fails on field 4. A fetch fails on fields 0, 1 and 5. A user store fails on fields other than 1 and 3. A supervisor store fails on even fields. Any other case below R3 is allowed.
- R3: A user-mode access of any kind to a page with field 6 or 7 is a privilege violation (code 3, status bits [1:0] = 2'b11).
- R4: Write permission is output only for a granted access without a fault whose page has its modified bit set, where writes are allowed: fields 1 and 3 in user mode, and fields 1, 3, 5 and 7 in supervisor mode. This holds for every access kind.
- R5: A nonzero walk fault type is a fault whatever the permission field. The status register takes the level in [9:8], the type in [4:2] and the valid bit [1].
- R6: On a fault, if the status register is nonzero and is not read in that cycle, the new value is 1 ORed with the new fault bits. Otherwise it is just the new fault bits. A nonzero status register is never cleared except by a read.
- R7: The fault address register takes the request address on every fault and holds it otherwise.
- R8: If no-fault mode is on or traps are disabled, a faulting access is granted, with write permission and no trap. The fault is still logged as in R5 and R6.
- R9: Otherwise a fault denies the access. It raises the instruction trap for a fetch and the data trap for a load or store, never both.
- R10: A status read strobe clears the status register at that edge. A fault in the same cycle is logged without overflow.
- R11: Reset clears all outputs and both registers. The response to a request appears exactly one cycle later, and the response valid output is low in cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| checkValid | input | 1 | A translated access is presented |
| accKind | input | 2 | 0 load, 1 store, 2 fetch |
| isSuper | input | 1 | Supervisor mode |
| permField | input | 3 | Page permission field |
| modBit | input | 1 | Page modified bit |
| walkType | input | 3 | Walk fault type, 0 = none |
| walkLevel | input | 2 | Walk level at which the fault occurred |
| noFaultMode | input | 1 | Suppress traps, grant faulting accesses |
| trapsEnabled | input | 1 | Traps enabled |
| faultVa | input | VA_W | Virtual address of the access |
| fsrRdEn | input | 1 | Status read strobe (clears status) |
| rspValid | output | 1 | Response valid |
| grant | output | 1 | Access allowed |
| writePerm | output | 1 | Write permission to install |
| trapInstr | output | 1 | Instruction access trap request |
| trapData | output | 1 | Data access trap request |
| fsrRdData | output | 10 | Fault status register |
| farOut | output | VA_W | Fault address register |

## Verification
The hardest state to reach is a fault that lands while the status register already holds a fault, with the read strobe both present and absent in that cycle. Only that combination separates overflow from clear-on-read. The stimulus sweeps every kind, mode, field, modified bit, no-fault and trap-enable combination, then every walk fault type and level. Reads are placed on a fixed fraction of cycles, so both orderings of read and fault occur many times. A model of the status and address registers follows each case.

// File: rtl/pac_pkg.sv
package pac_pkg;
  localparam int LVL_W   = 2;
  localparam int WTYPE_W = 3;
  localparam int IDX_W   = 3;
  localparam int FSR_W   = LVL_W + IDX_W + WTYPE_W + 2;

  typedef enum logic [1:0] {
    KIND_LOAD  = 2'b00,
    KIND_STORE = 2'b01,
    KIND_FETCH = 2'b10,
    KIND_RSVD  = 2'b11
  } accKind_e;

  typedef struct packed {
    logic             logFault;
    logic             clearFsr;
    logic [FSR_W-1:0] faultBits;
  } pacStrobe_t;

  // odd fields writable; user mode only below field 4
  function automatic logic writeAllowed(logic sup, logic [2:0] field);
    return field[0] && (sup || !field[2]);
  endfunction

  // 0 allowed, 2 protection error, 3 privilege violation
  function automatic logic [1:0] protCode(logic [IDX_W-1:0] idx, logic [2:0] field);
    logic ok;
    if (!idx[0] && field[2:1] == 2'b11) return 2'd3;
    case ({idx[2], idx[1]})
      2'b00:   ok = (field != 3'd4);
      2'b01:   ok = (field >= 3'd2) && (field != 3'd5);
      2'b10:   ok = writeAllowed(idx[0], field);
      default: ok = 1'b0;
    endcase
    return ok ? 2'd0 : 2'd2;
  endfunction
endpackage

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               checkValid,
  input  logic [1:0]         accKind,
  input  logic               isSuper,
  input  logic [2:0]         permField,
  input  logic               modBit,
  input  logic [WTYPE_W-1:0] walkType,
  input  logic [LVL_W-1:0]   walkLevel,
  input  logic               noFaultMode,
  input  logic               trapsEnabled,
  input  logic               fsrRdEn,
  output pacStrobe_t         strobe,
  output logic               rspValid,
  output logic               grant,
  output logic               writePerm,
  output logic               trapInstr,
  output logic               trapData
);
  logic [IDX_W-1:0] accIdx;
  logic [1:0]       errCode;
  logic             walkFault, isFault, override, isFetch;

  always_comb begin
    isFetch   = (accKind == KIND_FETCH);
    accIdx    = {accKind == KIND_STORE, isFetch, isSuper};
    errCode   = protCode(accIdx, permField);
    walkFault = (walkType != '0);
    isFault   = walkFault || (errCode != 2'd0);
    override  = noFaultMode || !trapsEnabled;

    strobe.logFault = checkValid && isFault;
    strobe.clearFsr = fsrRdEn;
    if (walkFault)
      strobe.faultBits = {walkLevel, accIdx, walkType, 2'b10};
    else
      strobe.faultBits = {{LVL_W{1'b0}}, accIdx, {WTYPE_W{1'b0}}, errCode | 2'b10};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      grant     <= 1'b0;
      writePerm <= 1'b0;
      trapInstr <= 1'b0;
      trapData  <= 1'b0;
    end else begin
      rspValid  <= checkValid;
      grant     <= checkValid && (!isFault || override);
      writePerm <= checkValid && (isFault ? override
                                          : (modBit && writeAllowed(isSuper, permField)));
      trapInstr <= checkValid && isFault && !override && isFetch;
      trapData  <= checkValid && isFault && !override && !isFetch;
    end
  end
endmodule

// File: rtl/pac_dpath.sv
module pac_dpath
  import pac_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pacStrobe_t       strobe,
  input  logic [VA_W-1:0]  faultVa,
  output logic [FSR_W-1:0] fsrQ,
  output logic [VA_W-1:0]  farQ
);
  logic [FSR_W-1:0] ovfBase;

  always_comb begin
    ovfBase = ((fsrQ != '0) && !strobe.clearFsr) ? FSR_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsrQ <= '0;
      farQ <= '0;
    end else begin
      if (strobe.logFault) begin
        fsrQ <= ovfBase | strobe.faultBits;
        farQ <= faultVa;
      end else if (strobe.clearFsr) begin
        fsrQ <= '0;
      end
    end
  end
endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import pac_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              checkValid,
  input  logic [1:0]        accKind,
  input  logic              isSuper,
  input  logic [2:0]        permField,
  input  logic              modBit,
  input  logic [2:0]        walkType,
  input  logic [1:0]        walkLevel,
  input  logic              noFaultMode,
  input  logic              trapsEnabled,
  input  logic [VA_W-1:0]   faultVa,
  input  logic              fsrRdEn,
  output logic              rspValid,
  output logic              grant,
  output logic              writePerm,
  output logic              trapInstr,
  output logic              trapData,
  output logic [9:0]        fsrRdData,
  output logic [VA_W-1:0]   farOut
);
  pacStrobe_t strobe;

  pac_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .checkValid(checkValid), .accKind(accKind),
    .isSuper(isSuper), .permField(permField), .modBit(modBit),
    .walkType(walkType), .walkLevel(walkLevel), .noFaultMode(noFaultMode),
    .trapsEnabled(trapsEnabled), .fsrRdEn(fsrRdEn), .strobe(strobe),
    .rspValid(rspValid), .grant(grant), .writePerm(writePerm),
    .trapInstr(trapInstr), .trapData(trapData)
  );

  pac_dpath #(.VA_W(VA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .faultVa(faultVa),
    .fsrQ(fsrRdData), .farQ(farOut)
  );
endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            checkValid,
  input logic            isSuper,
  input logic [2:0]      permField,
  input logic [2:0]      walkType,
  input logic            noFaultMode,
  input logic            trapsEnabled,
  input logic            fsrRdEn,
  input logic            rspValid,
  input logic            grant,
  input logic            writePerm,
  input logic            trapInstr,
  input logic            trapData,
  input logic [9:0]      fsrRdData,
  input logic [VA_W-1:0] farOut
);
  a_r9_trap_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({trapInstr, trapData}));

  a_r8_override_grants: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && (noFaultMode || !trapsEnabled) |=> grant && !trapInstr && !trapData);

  a_r11_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    checkValid |=> rspValid);

  a_r11_resp_idle: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> !rspValid && !grant && !writePerm);

  a_r7_far_holds: assert property (@(posedge clk) disable iff (!rstN)
    !checkValid |=> $stable(farOut));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    fsrRdEn && !checkValid |=> fsrRdData == 10'd0);

  a_r6_overflow_kept: assert property (@(posedge clk) disable iff (!rstN)
    (fsrRdData != 10'd0) && !fsrRdEn |=> fsrRdData != 10'd0);

  a_r4_wp_needs_grant: assert property (@(posedge clk) disable iff (!rstN)
    writePerm |-> grant);

  a_r3_priv_code: assert property (@(posedge clk) disable iff (!rstN)
    checkValid && !isSuper && permField[2:1] == 2'b11 && walkType == 3'd0
    |=> fsrRdData[1:0] == 2'b11);

  a_r5_deny_logged: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !grant |-> fsrRdData[1]);
endmodule

bind page_perm_check pac_checker #(.VA_W(VA_W)) chk_i (
  .clk(clk), .rstN(rstN), .checkValid(checkValid), .isSuper(isSuper),
  .permField(permField), .walkType(walkType), .noFaultMode(noFaultMode),
  .trapsEnabled(trapsEnabled), .fsrRdEn(fsrRdEn), .rspValid(rspValid),
  .grant(grant), .writePerm(writePerm), .trapInstr(trapInstr),
  .trapData(trapData), .fsrRdData(fsrRdData), .farOut(farOut)
);

// File: tb/page_perm_check_tb_top.sv
module page_perm_check_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        checkValid = 1'b0;
  logic [1:0]  accKind = 2'd0;
  logic        isSuper = 1'b0;
  logic [2:0]  permField = 3'd0;
  logic        modBit = 1'b0;
  logic [2:0]  walkType = 3'd0;
  logic [1:0]  walkLevel = 2'd0;
  logic        noFaultMode = 1'b0;
  logic        trapsEnabled = 1'b1;
  logic [31:0] faultVa = 32'd0;
  logic        fsrRdEn = 1'b0;
  logic        rspValid, grant, writePerm, trapInstr, trapData;
  logic [9:0]  fsrRdData;
  logic [31:0] farOut;

  int checks = 0;
  int errors = 0;
  logic [9:0]  mFsr = 10'd0;
  logic [31:0] mFar = 32'd0;

  always #2 clk = ~clk;

  page_perm_check #(.VA_W(32)) dut_i (
    .clk(clk), .rstN(rstN), .checkValid(checkValid), .accKind(accKind),
    .isSuper(isSuper), .permField(permField), .modBit(modBit),
    .walkType(walkType), .walkLevel(walkLevel), .noFaultMode(noFaultMode),
    .trapsEnabled(trapsEnabled), .faultVa(faultVa), .fsrRdEn(fsrRdEn),
    .rspValid(rspValid), .grant(grant), .writePerm(writePerm),
    .trapInstr(trapInstr), .trapData(trapData), .fsrRdData(fsrRdData),
    .farOut(farOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expCode(int kind, bit sup, int f);
    if (!sup && f >= 6) return 3;
    if (kind == 0) return (f == 4) ? 2 : 0;
    if (kind == 2) return (f == 0 || f == 1 || f == 5) ? 2 : 0;
    if (sup) return (f % 2 == 1) ? 0 : 2;
    return (f == 1 || f == 3) ? 0 : 2;
  endfunction

  function automatic bit expWr(bit sup, int f);
    if (sup) return (f % 2) == 1;
    return (f == 1 || f == 3);
  endfunction

  task automatic runCase(input int kind, input bit sup, input int f, input bit mod,
                         input bit nf, input bit te, input int wt, input int wl,
                         input bit rd, input logic [31:0] va);
    int code, idx, bits;
    bit fault, ovr;
    idx  = (kind == 1 ? 4 : 0) + (kind == 2 ? 2 : 0) + (sup ? 1 : 0);
    code = expCode(kind, sup, f);
    if (wt != 0) begin
      fault = 1;
      bits  = wl * 256 + idx * 32 + wt * 4 + 2;
    end else begin
      fault = (code != 0);
      bits  = idx * 32 + code;
    end
    ovr = nf || !te;
    accKind = 2'(kind); isSuper = sup; permField = 3'(f); modBit = mod;
    noFaultMode = nf; trapsEnabled = te; walkType = 3'(wt); walkLevel = 2'(wl);
    fsrRdEn = rd; faultVa = va; checkValid = 1'b1;
    @(negedge clk);
    checkValid = 1'b0; fsrRdEn = 1'b0;
    if (fault) begin
      mFsr = ((mFsr != 0 && !rd) ? 10'd1 : 10'd0) | 10'(bits);
      mFar = va;
    end else if (rd) mFsr = 10'd0;
    chk("R11 rspValid", 32'(rspValid), 32'd1);
    chk(wt != 0 ? "R5 grant" : (code == 3 ? "R3 grant" : "R2 grant"),
        32'(grant), 32'(!fault || ovr));
    chk(ovr ? "R8 writePerm" : "R4 writePerm", 32'(writePerm),
        32'(fault ? ovr : (mod && expWr(sup, f))));
    chk("R9 trapInstr", 32'(trapInstr), 32'(fault && !ovr && kind == 2));
    chk("R9 trapData", 32'(trapData), 32'(fault && !ovr && kind != 2));
    chk(rd ? "R10 fsr" : (wt != 0 ? "R5 fsr" : "R6 R1 fsr"), 32'(fsrRdData), 32'(mFsr));
    chk("R7 far", farOut, mFar);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    n = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R11 reset rspValid", 32'(rspValid), 32'd0);
    chk("R11 reset fsr", 32'(fsrRdData), 32'd0);
    chk("R11 reset far", farOut, 32'd0);
    chk("R11 reset grant", 32'(grant), 32'd0);
    @(negedge clk);
    chk("R11 idle rspValid", 32'(rspValid), 32'd0);
    for (int kind = 0; kind < 3; kind++)
      for (int s = 0; s < 2; s++)
        for (int f = 0; f < 8; f++)
          for (int m = 0; m < 2; m++)
            for (int o = 0; o < 4; o++) begin
              runCase(kind, s[0], f, m[0], o[0], !o[1], 0, 0, (n % 5) == 0,
                      32'h1000_0000 + 32'(n) * 32'h1234);
              n++;
            end
    for (int kind = 0; kind < 3; kind++)
      for (int wt = 1; wt < 8; wt++)
        for (int wl = 0; wl < 4; wl++) begin
          runCase(kind, wl[0], 3, 1'b1, (n % 7) == 0, 1'b1, wt, wl, (n % 3) == 0,
                  32'h8000_0000 ^ (32'(n) << 12));
          n++;
        end
    // R6 then R10: back-to-back faults without read, then a read collision
    runCase(0, 1'b0, 4, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0, 32'hAAAA_0000);
    runCase(2, 1'b0, 7, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0, 32'hBBBB_0000);
    runCase(1, 1'b1, 2, 1'b0, 1'b0, 1'b1, 0, 0, 1'b1, 32'hCCCC_0000);
    @(negedge clk);
    chk("R11 idle after", 32'(rspValid), 32'd0);
    chk("R7 far held idle", farOut, mFar);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule